// File: doc/BRIEF.md
# I2C Command Queue Sequencer

This block runs I2C transfers from stored command programs, not from one register write per transfer. One bus master owns two command queues: a deep queue 0 and a shallow queue 1. Each queue is a FIFO of 32-bit command words. The host pushes words into a queue, writes an execute count for that queue, and then pulses the queue's start bit. The sequencer then consumes exactly that many words, decoding an opcode from each command.

Write and read commands turn into a stream of byte operations for a separate bit-level bus engine. Each byte operation carries flags for start condition, stop condition and direction. Bytes returned by reads are packed into a small read buffer that the host drains. A report command and a slave NACK each produce per-queue status, and a lock command gives one queue sole use of the bus until it unlocks.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, both queue levels and the read buffer level are 0, `eng_req_o` is low, and `nack_err_o` and `lock_o` are 0.
- R2: Each `load_we_i` pulse pushes `load_data_i` into the queue picked by `load_q_i`, raising that queue's level by one. Each word the sequencer consumes lowers the level by one.
- R3: A pulse on `start_i[q]` makes queue q consume exactly the count last written for it through `exec_we_i`/`exec_q_i`. Words beyond that count stay in the queue.
- R4: A set-param word (opcode 1 in bits [3:0]) stores a 7-bit slave id from bits [10:4] for its queue. Every transfer of that queue then begins with the address byte {id, rw}.
- R5: A write word (opcode 9) sends n payload bytes, where n is in bits [7:4]. The address byte comes first with `eng_start_o` set. The payload follows in little-endian order: bytes 1 to 3 of the command word, then bytes 0 to 3 of each following word. `eng_stop_o` is set on the last byte; when n = 0 it is set on the address byte.
- R6: A read word (opcode 10) sends the address byte with rw = 1 and `eng_start_o` set. It then issues n read operations with `eng_rd_o` high and `eng_stop_o` on the last one.
- R7: A read first clears the read buffer. It then stores the slave id as byte 0, followed by the data bytes, four per word in little-endian order. The buffer ends at level n/4+1 words, and `rd_done_o` pulses for one cycle exactly once. Each `rbuf_re_i` pulse pops the buffer head shown on `rbuf_data_o`.
- R8: A report word (opcode 8) pulses `report_o[q]` for one cycle when bit 8 is set. When bit 8 is clear it produces no pulse.
- R9: A NACK returned with a non-read byte sets `nack_err_o[q]` and stops queue q, leaving its unconsumed words in place. `halt_i[q]` clears the error, empties the queue and cancels its run; the queue then accepts new work.
- R10: A lock word (opcode 6) marks its queue as owner on `lock_o`. The other queue starts no command until the unlock word (opcode 7) runs.
- R11: Opcodes 2 to 5 and 0, 11 to 15 are consumed as no-ops, with no bus operation and no status.
- R12: When both queues are ready and no lock is held, queue 0 executes its next command first.
- R13: `eng_req_o` stays high with stable byte, flags and direction until `eng_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_we_i | input | 1 | Push one command word |
| load_q_i | input | 1 | Target queue for the push |
| load_data_i | input | 32 | Command word |
| exec_we_i | input | 1 | Write the execute count |
| exec_q_i | input | 1 | Queue for the execute count |
| exec_cnt_i | input | LW | Number of words to run |
| start_i | input | 2 | Per-queue start pulse |
| halt_i | input | 2 | Per-queue halt: flush, clear error |
| q0_level_o | output | LW | Words held in queue 0 |
| q1_level_o | output | LW | Words held in queue 1 |
| eng_req_o | output | 1 | Byte operation request |
| eng_start_o | output | 1 | Start condition before this byte |
| eng_stop_o | output | 1 | Stop condition after this byte |
| eng_rd_o | output | 1 | Byte is received, not sent |
| eng_wdata_o | output | 8 | Byte to send |
| eng_done_i | input | 1 | Byte operation complete |
| eng_nack_i | input | 1 | Slave did not acknowledge |
| eng_rdata_i | input | 8 | Received byte |
| rbuf_re_i | input | 1 | Pop read buffer |
| rbuf_data_o | output | 32 | Read buffer head word |
| rbuf_level_o | output | RLW | Read buffer level |
| rd_done_o | output | 1 | Read command finished |
| report_o | output | 2 | Per-queue report pulse |
| nack_err_o | output | 2 | Per-queue sticky NACK error |
| lock_o | output | 2 | Queue holding the bus lock |

## Verification
The properties assume a well-behaved engine: it raises `eng_done_i` for a single cycle and only in answer to `eng_req_o`. They also assume a host that never pushes into a full queue and whose execute counts match the words each command needs. The host pulses `halt_i` only for a queue that is not in the middle of a command. The bench's engine model answers each request after two cycles and drops done on the next cycle. Its stimulus loads complete programs before starting them and halts only after a NACK has stopped the queue.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] OP_SETP   = 4'd1;
  localparam logic [3:0] OP_LOCK   = 4'd6;
  localparam logic [3:0] OP_UNLOCK = 4'd7;
  localparam logic [3:0] OP_REPORT = 4'd8;
  localparam logic [3:0] OP_WRITE  = 4'd9;
  localparam logic [3:0] OP_READ   = 4'd10;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_NEXT} seq_st_e;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [LVL_W-1:0] level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             do_push, do_pop;

  assign do_push = push_i && !flush_i && (cnt != LVL_W'(DEPTH));
  assign do_pop  = pop_i && !flush_i && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + LVL_W'(1);
        2'b01:   cnt <= cnt - LVL_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= data_i;
  end

  assign head_o  = mem[rp];
  assign level_o = cnt;
endmodule

// File: rtl/byte_packer.sv
module byte_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        byte_v_i,
  input  logic [7:0]  byte_i,
  input  logic        last_i,
  output logic        word_v_o,
  output logic [31:0] word_o
);
  logic [31:0] acc, nxt;
  logic [1:0]  idx;

  always_comb begin
    nxt = acc;
    nxt[8*idx +: 8] = byte_i;
  end

  assign word_v_o = byte_v_i && ((idx == 2'd3) || last_i);
  assign word_o   = nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc <= '0;
      idx <= '0;
    end else if (clr_i || word_v_o) begin
      acc <= '0;
      idx <= '0;
    end else if (byte_v_i) begin
      acc <= nxt;
      idx <= idx + 2'd1;
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cq_pkg::*;
#(
  parameter int Q0_DEPTH   = 64,
  parameter int Q1_DEPTH   = 16,
  parameter int RBUF_DEPTH = 4,
  localparam int LW  = $clog2(Q0_DEPTH + 1),
  localparam int RLW = $clog2(RBUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic              load_q_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic              exec_we_i,
  input  logic              exec_q_i,
  input  logic [LW-1:0]     exec_cnt_i,
  input  logic [1:0]        start_i,
  input  logic [1:0]        halt_i,
  output logic [LW-1:0]     q0_level_o,
  output logic [LW-1:0]     q1_level_o,
  output logic              eng_req_o,
  output logic              eng_start_o,
  output logic              eng_stop_o,
  output logic              eng_rd_o,
  output logic [7:0]        eng_wdata_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [7:0]        eng_rdata_i,
  input  logic              rbuf_re_i,
  output logic [WORD_W-1:0] rbuf_data_o,
  output logic [RLW-1:0]    rbuf_level_o,
  output logic              rd_done_o,
  output logic [1:0]        report_o,
  output logic [1:0]        nack_err_o,
  output logic [1:0]        lock_o
);
  localparam int NQ = 2;

  logic [WORD_W-1:0] q_head [NQ];
  logic [LW-1:0]     q_lvl  [NQ];
  logic [NQ-1:0]     push_q, pop_q, runnable;
  logic [LW-1:0]     exec_r [NQ];
  logic [LW-1:0]     rem_r  [NQ];
  logic [6:0]        sid_r  [NQ];
  logic [NQ-1:0]     err_r, report_r;
  logic              lock_v, lock_q, aq;
  seq_st_e           st;
  logic [WORD_W-1:0] cur_w, head_a;
  logic [1:0]        bi;
  logic [3:0]        left;
  logic              is_rd, start_r, stop_r, rd_r, rd_done_r;
  logic [7:0]        byte_r;
  logic              sel_v, sel;
  logic [3:0]        op;
  logic [3:0]        nbytes;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam int D = (q == 0) ? Q0_DEPTH : Q1_DEPTH;
    assign push_q[q] = load_we_i && (load_q_i == 1'(q));
    cmd_fifo #(.WIDTH(WORD_W), .DEPTH(D), .LVL_W(LW)) u_fifo (
      .clk_i, .rst_ni,
      .flush_i(halt_i[q]),
      .push_i (push_q[q]),
      .data_i (load_data_i),
      .pop_i  (pop_q[q]),
      .head_o (q_head[q]),
      .level_o(q_lvl[q])
    );
    assign runnable[q] = (rem_r[q] != '0) && !err_r[q] && (q_lvl[q] != '0);
  end

  assign head_a = q_head[aq];
  assign op     = head_a[3:0];
  assign nbytes = head_a[7:4];

  always_comb begin
    if (lock_v) begin
      sel_v = runnable[lock_q];
      sel   = lock_q;
    end else begin
      sel_v = |runnable;
      sel   = !runnable[0];
    end
  end

  always_comb begin
    pop_q = '0;
    if (st == ST_FETCH || (st == ST_NEXT && !is_rd && bi == 2'd0)) pop_q[aq] = 1'b1;
  end

  // read data packing
  logic        pk_v, pk_word_v, pk_clr;
  logic [31:0] pk_word;
  assign pk_clr = (st == ST_FETCH) && (op == OP_READ);
  assign pk_v   = (st == ST_XFER) && eng_done_i && is_rd && (rd_r || !eng_nack_i);

  byte_packer u_pack (
    .clk_i, .rst_ni,
    .clr_i   (pk_clr),
    .byte_v_i(pk_v),
    .byte_i  (rd_r ? eng_rdata_i : {1'b0, sid_r[aq]}),
    .last_i  (left == 4'd0),
    .word_v_o(pk_word_v),
    .word_o  (pk_word)
  );

  cmd_fifo #(.WIDTH(WORD_W), .DEPTH(RBUF_DEPTH), .LVL_W(RLW)) u_rbuf (
    .clk_i, .rst_ni,
    .flush_i(pk_clr),
    .push_i (pk_word_v),
    .data_i (pk_word),
    .pop_i  (rbuf_re_i),
    .head_o (rbuf_data_o),
    .level_o(rbuf_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int q = 0; q < NQ; q++) begin
        exec_r[q] <= '0;
        rem_r[q]  <= '0;
        sid_r[q]  <= '0;
      end
      err_r     <= '0;
      report_r  <= '0;
      lock_v    <= 1'b0;
      lock_q    <= 1'b0;
      aq        <= 1'b0;
      st        <= ST_IDLE;
      cur_w     <= '0;
      bi        <= '0;
      left      <= '0;
      is_rd     <= 1'b0;
      start_r   <= 1'b0;
      stop_r    <= 1'b0;
      rd_r      <= 1'b0;
      byte_r    <= '0;
      rd_done_r <= 1'b0;
    end else begin
      report_r  <= '0;
      rd_done_r <= pk_word_v && (left == 4'd0);
      for (int q = 0; q < NQ; q++) begin
        if (exec_we_i && exec_q_i == 1'(q)) exec_r[q] <= exec_cnt_i;
        if (halt_i[q])                             rem_r[q] <= '0;
        else if (start_i[q])                       rem_r[q] <= exec_r[q];
        else if (pop_q[q] && rem_r[q] != '0)       rem_r[q] <= rem_r[q] - LW'(1);
      end
      case (st)
        ST_IDLE: if (sel_v) begin
          aq <= sel;
          st <= ST_FETCH;
        end
        ST_FETCH: begin
          st <= ST_IDLE;
          case (op)
            OP_SETP:   sid_r[aq] <= head_a[10:4];
            OP_LOCK:   begin lock_v <= 1'b1; lock_q <= aq; end
            OP_UNLOCK: lock_v <= 1'b0;
            OP_REPORT: report_r[aq] <= head_a[8];
            OP_WRITE, OP_READ: begin
              cur_w   <= head_a;
              bi      <= 2'd1;
              left    <= nbytes;
              is_rd   <= (op == OP_READ);
              byte_r  <= {sid_r[aq], op == OP_READ};
              start_r <= 1'b1;
              stop_r  <= (nbytes == 4'd0);
              rd_r    <= 1'b0;
              st      <= ST_XFER;
            end
            default: ;
          endcase
        end
        ST_XFER: if (eng_done_i) begin
          if (eng_nack_i && !rd_r) begin
            err_r[aq] <= 1'b1;
            st        <= ST_IDLE;
          end else begin
            st <= (left == 4'd0) ? ST_IDLE : ST_NEXT;
          end
        end
        ST_NEXT: begin
          start_r <= 1'b0;
          left    <= left - 4'd1;
          stop_r  <= (left == 4'd1);
          st      <= ST_XFER;
          if (is_rd) begin
            rd_r   <= 1'b1;
            byte_r <= 8'h00;
          end else begin
            // crossing into a new payload word pops it from the queue
            byte_r <= (bi == 2'd0) ? head_a[7:0] : cur_w[8*bi +: 8];
            if (bi == 2'd0) cur_w <= head_a;
            bi <= bi + 2'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
      for (int q = 0; q < NQ; q++) begin
        if (halt_i[q]) begin
          err_r[q] <= 1'b0;
          if (lock_q == 1'(q)) lock_v <= 1'b0;
        end
      end
    end
  end

  assign q0_level_o  = q_lvl[0];
  assign q1_level_o  = q_lvl[1];
  assign eng_req_o   = (st == ST_XFER);
  assign eng_start_o = start_r;
  assign eng_stop_o  = stop_r;
  assign eng_rd_o    = rd_r;
  assign eng_wdata_o = byte_r;
  assign rd_done_o   = rd_done_r;
  assign report_o    = report_r;
  assign nack_err_o  = err_r;
  assign lock_o      = lock_v ? (lock_q ? 2'b10 : 2'b01) : 2'b00;
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk #(
  parameter int LW = 7,
  parameter int RLW = 3,
  parameter int Q1_DEPTH = 16,
  parameter int RBUF_DEPTH = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    halt_i,
  input logic [LW-1:0] q1_level_o,
  input logic          eng_req_o,
  input logic          eng_stop_o,
  input logic          eng_rd_o,
  input logic [7:0]    eng_wdata_o,
  input logic          eng_done_i,
  input logic          eng_nack_i,
  input logic [RLW-1:0] rbuf_level_o,
  input logic          rd_done_o,
  input logic [1:0]    report_o,
  input logic [1:0]    nack_err_o,
  input logic [1:0]    lock_o
);
  a_r13_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_wdata_o) && $stable(eng_rd_o) && $stable(eng_stop_o));

  a_r10_lock_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lock_o));

  a_r8_report_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (report_o != 2'b00) |=> (report_o == 2'b00));

  a_r7_rd_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);

  a_r9_err_sticky0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_err_o[0] && !halt_i[0] |=> nack_err_o[0]);

  a_r9_err_sticky1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_err_o[1] && !halt_i[1] |=> nack_err_o[1]);

  a_r9_nack_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_done_i && eng_nack_i && !eng_rd_o && (halt_i == 2'b00) |=> (nack_err_o != 2'b00));

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q1_level_o <= LW'(Q1_DEPTH));

  a_r7_rbuf_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbuf_level_o <= RLW'(RBUF_DEPTH));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(
  .LW(LW), .RLW(RLW), .Q1_DEPTH(Q1_DEPTH), .RBUF_DEPTH(RBUF_DEPTH)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i), .q1_level_o(q1_level_o),
  .eng_req_o(eng_req_o), .eng_stop_o(eng_stop_o), .eng_rd_o(eng_rd_o),
  .eng_wdata_o(eng_wdata_o), .eng_done_i(eng_done_i), .eng_nack_i(eng_nack_i),
  .rbuf_level_o(rbuf_level_o), .rd_done_o(rd_done_o), .report_o(report_o),
  .nack_err_o(nack_err_o), .lock_o(lock_o)
);

// File: tb/test_i2c_cmd_seq.sv
module test_i2c_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 7;
  localparam int RLW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic load_we = 0, load_q = 0, exec_we = 0, exec_q = 0;
  logic [31:0] load_data = '0;
  logic [LW-1:0] exec_cnt = '0;
  logic [1:0] start = '0, halt = '0;
  logic [LW-1:0] q0_lvl, q1_lvl;
  logic eng_req, eng_start, eng_stop, eng_rd;
  logic [7:0] eng_wdata;
  logic eng_done = 0, eng_nack = 0;
  logic [7:0] eng_rdata = '0;
  logic rbuf_re = 0;
  logic [31:0] rbuf_data;
  logic [RLW-1:0] rbuf_lvl;
  logic rd_done;
  logic [1:0] report, nack_err, lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_seq i_i2c_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .load_we_i(load_we), .load_q_i(load_q), .load_data_i(load_data),
    .exec_we_i(exec_we), .exec_q_i(exec_q), .exec_cnt_i(exec_cnt),
    .start_i(start), .halt_i(halt),
    .q0_level_o(q0_lvl), .q1_level_o(q1_lvl),
    .eng_req_o(eng_req), .eng_start_o(eng_start), .eng_stop_o(eng_stop),
    .eng_rd_o(eng_rd), .eng_wdata_o(eng_wdata),
    .eng_done_i(eng_done), .eng_nack_i(eng_nack), .eng_rdata_i(eng_rdata),
    .rbuf_re_i(rbuf_re), .rbuf_data_o(rbuf_data), .rbuf_level_o(rbuf_lvl),
    .rd_done_o(rd_done), .report_o(report), .nack_err_o(nack_err), .lock_o(lock)
  );

  int checks = 0, failures = 0;
  int items_seen = 0, nack_at = -1;
  int rep_cnt0 = 0, rep_cnt1 = 0, rd_done_cnt = 0;
  logic [7:0] rd_next = 8'hC0;
  logic [10:0] exp_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected byte operation: {start, stop, rd, data}
  task automatic expect_op(logic st, logic sp, logic rd, logic [7:0] d);
    exp_q.push_back({st, sp, rd, d});
  endtask

  // engine model and scoreboard monitor
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (eng_done) begin
        eng_done = 0;
        eng_nack = 0;
      end else if (eng_req) begin
        wcnt++;
        if (wcnt == 2) begin
          logic [10:0] act;
          wcnt = 0;
          act = {eng_start, eng_stop, eng_rd, eng_rd ? 8'h00 : eng_wdata};
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R5/R6 unexpected bus op actual=%h expected=none", act);
          end else begin
            logic [10:0] e;
            e = exp_q.pop_front();
            if (act !== e) begin
              failures++;
              $display("FAIL R5/R6 bus op actual=%h expected=%h", act, e);
            end
          end
          eng_done = 1;
          eng_nack = (items_seen == nack_at);
          if (eng_rd) begin
            eng_rdata = rd_next;
            rd_next = rd_next + 8'd1;
          end
          items_seen++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (report[0]) rep_cnt0++;
      if (report[1]) rep_cnt1++;
      if (rd_done) rd_done_cnt++;
    end
  end

  task automatic load(logic q, logic [31:0] w);
    @(negedge clk); load_we = 1; load_q = q; load_data = w;
    @(negedge clk); load_we = 0;
  endtask

  task automatic set_exec(logic q, int n);
    @(negedge clk); exec_we = 1; exec_q = q; exec_cnt = LW'(n);
    @(negedge clk); exec_we = 0;
  endtask

  task automatic go(logic [1:0] m);
    @(negedge clk); start = m;
    @(negedge clk); start = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk("R5 all expected ops seen", exp_q.size(), 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 q0 level", q0_lvl, 0);
    chk("R1 q1 level", q1_lvl, 0);
    chk("R1 rbuf level", rbuf_lvl, 0);
    chk("R1 req/err/lock", {eng_req, nack_err, lock}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R8: multi-word write with report, plus trailing no-op
    load(0, 32'h0000_0501);
    load(0, 32'h1312_1169);
    load(0, 32'h0016_1514);
    load(0, 32'h0000_0108);
    load(0, 32'h0000_0002);
    chk("R2 q0 level after loads", q0_lvl, 5);
    expect_op(1, 0, 0, 8'hA0);
    expect_op(0, 0, 0, 8'h11);
    expect_op(0, 0, 0, 8'h12);
    expect_op(0, 0, 0, 8'h13);
    expect_op(0, 0, 0, 8'h14);
    expect_op(0, 0, 0, 8'h15);
    expect_op(0, 1, 0, 8'h16);
    set_exec(0, 4);
    go(2'b01);
    drain();
    chk("R3 words beyond count remain", q0_lvl, 1);
    chk("R8 report pulse with bit 8", rep_cnt0, 1);

    // R11 no-ops and R8 report without bit 8
    load(0, 32'h0000_000F);
    load(0, 32'h0000_0008);
    set_exec(0, 3);
    go(2'b01);
    repeat (20) @(negedge clk);
    chk("R11 no-op consumed, R2 level", q0_lvl, 0);
    chk("R11 no bus op from no-ops", items_seen, 7);
    chk("R8 no pulse without bit 8", rep_cnt0, 1);

    // R6 R7 read with address write on queue 1
    load(1, 32'h0000_02A1);
    load(1, 32'h0000_1019);
    load(1, 32'h0000_005A);
    expect_op(1, 0, 0, 8'h54);
    expect_op(0, 1, 0, 8'h10);
    expect_op(1, 0, 0, 8'h55);
    expect_op(0, 0, 1, 8'h00);
    expect_op(0, 0, 1, 8'h00);
    expect_op(0, 0, 1, 8'h00);
    expect_op(0, 0, 1, 8'h00);
    expect_op(0, 1, 1, 8'h00);
    set_exec(1, 3);
    go(2'b10);
    drain();
    chk("R7 rbuf level n/4+1", rbuf_lvl, 2);
    chk("R7 rd_done once", rd_done_cnt, 1);
    chk("R7 word0 id then data", rbuf_data, 32'hC2C1_C02A);
    @(negedge clk); rbuf_re = 1;
    @(negedge clk); rbuf_re = 0;
    chk("R7 word1", rbuf_data, 32'h0000_C4C3);
    chk("R2 q1 drained", q1_lvl, 0);

    // R10 lock keeps queue 0 out
    load(1, 32'h0000_0006);
    load(1, 32'h0000_3319);
    load(1, 32'h0000_4419);
    load(1, 32'h0000_0007);
    load(0, 32'h0000_5519);
    expect_op(1, 0, 0, 8'h54);
    expect_op(0, 1, 0, 8'h33);
    expect_op(1, 0, 0, 8'h54);
    expect_op(0, 1, 0, 8'h44);
    expect_op(1, 0, 0, 8'hA0);
    expect_op(0, 1, 0, 8'h55);
    set_exec(1, 4);
    set_exec(0, 1);
    go(2'b10);
    for (int i = 0; i < 50 && lock == 2'b00; i++) @(negedge clk);
    chk("R10 lock owner queue 1", lock, 2'b10);
    go(2'b01);
    drain();
    chk("R10 lock released", lock, 2'b00);

    // R12 queue 0 first when both start together
    load(1, 32'h0000_7719);
    load(0, 32'h0000_6619);
    expect_op(1, 0, 0, 8'hA0);
    expect_op(0, 1, 0, 8'h66);
    expect_op(1, 0, 0, 8'h54);
    expect_op(0, 1, 0, 8'h77);
    set_exec(1, 1);
    set_exec(0, 1);
    go(2'b11);
    drain();

    // R9 NACK on first payload byte
    load(0, 32'h00BB_AA29);
    load(0, 32'h0000_0108);
    nack_at = items_seen + 1;
    expect_op(1, 0, 0, 8'hA0);
    expect_op(0, 0, 0, 8'hAA);
    set_exec(0, 2);
    go(2'b01);
    drain();
    chk("R9 nack error set", nack_err, 2'b01);
    chk("R9 remaining word kept", q0_lvl, 1);
    chk("R9 no report after nack", rep_cnt0, 1);
    @(negedge clk); halt = 2'b01;
    @(negedge clk); halt = 2'b00;
    chk("R9 halt clears error", nack_err, 2'b00);
    chk("R9 halt flushes queue", q0_lvl, 0);

    // R5 zero-length write after recovery
    load(0, 32'h0000_0009);
    expect_op(1, 1, 0, 8'hA0);
    set_exec(0, 1);
    go(2'b01);
    drain();
    chk("R9 queue resumes after halt", q0_lvl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule